// File: doc/BRIEF.md
# Clock Generator Configuration Slave (Two-Wire, Block Transfer)

This block is the configuration front end of a clock synthesizer. It listens on a two-wire serial bus (SCL/SDA, open drain) and holds the control bytes that gate the clock outputs, choose the spread-spectrum setting, set output skew and pick the frequency. The PLL, dividers and pad drivers sit outside and consume the register fields through dedicated output ports.

A write transfer has no register-address phase. After the slave address (R/W = 0) is acknowledged, the master sends two filler bytes, a command byte and then a count byte. Both are acknowledged and their values are dropped. Every byte after that goes to the next register, starting at register 0. A read transfer (R/W = 1) returns registers from register 0 upward, with no filler bytes. Registers 11 and 12 are constant identification bytes. The upper five bits of register 1 report the frequency-select straps sampled just after reset.

Top module: `clkgen_cfg_i2c`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal the parameter SLV_ADDR. On any other address it does not acknowledge and ignores the rest of the transfer, up to the next start condition.
- R2: In a write transfer, the two bytes after the address are acknowledged and change no register, whatever their value. The first byte after them lands in register 0.
- R3: Each further write byte is acknowledged and goes to the register one above the previous byte. Bytes aimed at register 11, register 12 or any register above 12 are acknowledged and discarded.
- R4: After reset the registers hold these values: register 0 = 0x00, register 1 bits 2:0 = 3'b001, registers 2, 3 and 4 = 0xFF, register 5 = 0x93, registers 6 to 10 = 0x00.
- R5: The output fields are mapped as follows. clk_en_o = {reg4, reg3, reg2}, where a 1 means the output runs. skew_sdram_o = reg5[7:5]. skew_3v66_o = reg5[4:2]. cpu_en_o = reg5[1:0]. ss_cfg_o = reg1[2:0], where bit 2 = 1 selects the smaller amplitude, bit 1 enables spreading and bit 0 = 1 selects centre spreading. freq_sel_o = reg0. mn_cfg_o = {reg10, reg9, reg8, reg7, reg6}.
- R6: Register 1 bits 7:3 read back strap_fs_i[4:0] as sampled in the first clock after reset is released. Writes never change these bits.
- R7: Register 11 always reads 0x50 and register 12 always reads 0x12.
- R8: In a read transfer, bytes come from register 0 upward, MSB first, one byte for each master acknowledge. A master NACK ends the transfer. Registers above 12 read as 0x00.
- R9: A start or repeated start, at any point, sends the slave back to address reception with the register pointer at 0. A stop returns it to idle. Neither one depends on the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, well above the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up) |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_fs_i | input | 5 | Hardware frequency-select straps |
| freq_sel_o | output | 8 | Register 0 |
| ss_cfg_o | output | 3 | Spread-spectrum controls |
| clk_en_o | output | 24 | Per-output clock enables |
| cpu_en_o | output | 2 | CPU clock enables |
| skew_sdram_o | output | 3 | CPU-to-SDRAM skew code |
| skew_3v66_o | output | 3 | CPU-to-66 MHz skew code |
| mn_cfg_o | output | 40 | Frequency synthesis bytes (registers 6 to 10) |

## Verification
Two events can fall into the same acknowledge slot: the register write and pointer advance for a data byte, and a repeated start that must throw the pointer back to 0. The bench issues a repeated start straight after the acknowledge clock of a data byte and then writes a single byte. The byte from before the restart must stay in its register, and the new byte must land in register 0. The reference model compares every register field at the ports on every clock, so an early or late commit, or a misplaced pointer, shows up as a mismatch.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_CMD, S_CMD_ACK, S_CNT, S_CNT_ACK,
    S_WDAT, S_WDAT_ACK, S_RDAT, S_RDAT_ACK
  } cfg_fsm_e;

  localparam int unsigned LAST_RW = 10;  // highest writable register
  localparam int unsigned ID0_IDX = 11;
  localparam int unsigned ID1_IDX = 12;
  localparam logic [7:0]  ID0_VAL = 8'h50;
  localparam logic [7:0]  ID1_VAL = 8'h12;
  localparam int unsigned STRAP_W = 5;

  function automatic logic [7:0] reg_default(int unsigned idx);
    case (idx)
      1:       return 8'h01;
      2, 3, 4: return 8'hFF;
      5:       return 8'h93;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/i2c_sync_detect.sv
module i2c_sync_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
  logic scl_s, sda_s, scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s      = scl_sr[SYNC_STAGES-1];
  assign sda_s      = sda_sr[SYNC_STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_cfg_fsm.sv
module i2c_cfg_fsm
  import clkcfg_pkg::*;
#(
  parameter logic [6:0]  SLV_ADDR = 7'h69,
  parameter int unsigned PTR_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             sda_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [7:0]       rd_data_i,
  output logic [PTR_W-1:0] rd_addr_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic [7:0]       wr_data_o,
  output logic             sda_oe_o
);
  cfg_fsm_e         state_q;
  logic [3:0]       bit_cnt_q;
  logic [7:0]       shift_q, tx_q;
  logic [PTR_W-1:0] ptr_q, ptr_inc;
  logic             rnw_q, oe_q, rx_state, byte_done;

  assign ptr_inc   = (&ptr_q) ? ptr_q : ptr_q + 1'b1;  // saturate, never wrap to 0
  assign rx_state  = (state_q == S_ADDR) || (state_q == S_CMD) ||
                     (state_q == S_CNT)  || (state_q == S_WDAT);
  assign byte_done = scl_fall_i && (bit_cnt_q == 4'd8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      bit_cnt_q <= '0;
      shift_q   <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      rnw_q     <= 1'b0;
      oe_q      <= 1'b0;
    end else if (start_i) begin
      state_q   <= S_ADDR;
      bit_cnt_q <= '0;
      ptr_q     <= '0;
      oe_q      <= 1'b0;
    end else if (stop_i) begin
      state_q   <= S_IDLE;
      oe_q      <= 1'b0;
    end else if (rx_state) begin
      if (scl_rise_i && bit_cnt_q < 4'd8) begin
        shift_q   <= {shift_q[6:0], sda_i};
        bit_cnt_q <= bit_cnt_q + 1'b1;
      end else if (byte_done) begin
        bit_cnt_q <= '0;
        case (state_q)
          S_ADDR: begin
            if (shift_q[7:1] == SLV_ADDR) begin
              oe_q    <= 1'b1;
              rnw_q   <= shift_q[0];
              state_q <= S_ADDR_ACK;
            end else begin
              state_q <= S_IDLE;
            end
          end
          S_CMD:   begin oe_q <= 1'b1; state_q <= S_CMD_ACK; end
          S_CNT:   begin oe_q <= 1'b1; state_q <= S_CNT_ACK; end
          default: begin oe_q <= 1'b1; state_q <= S_WDAT_ACK; ptr_q <= ptr_inc; end
        endcase
      end
    end else begin
      case (state_q)
        S_ADDR_ACK, S_RDAT_ACK: begin
          if (state_q == S_RDAT_ACK && scl_rise_i && sda_i) begin
            state_q <= S_IDLE;  // master NACK
          end else if (scl_fall_i) begin
            if (state_q == S_ADDR_ACK && !rnw_q) begin
              oe_q    <= 1'b0;
              state_q <= S_CMD;
            end else begin
              tx_q      <= rd_data_i;
              oe_q      <= ~rd_data_i[7];
              bit_cnt_q <= 4'd1;
              ptr_q     <= ptr_inc;
              state_q   <= S_RDAT;
            end
          end
        end
        S_CMD_ACK:  if (scl_fall_i) begin oe_q <= 1'b0; state_q <= S_CNT;  end
        S_CNT_ACK:  if (scl_fall_i) begin oe_q <= 1'b0; state_q <= S_WDAT; end
        S_WDAT_ACK: if (scl_fall_i) begin oe_q <= 1'b0; state_q <= S_WDAT; end
        S_RDAT: begin
          if (scl_fall_i) begin
            if (bit_cnt_q == 4'd8) begin
              oe_q    <= 1'b0;
              state_q <= S_RDAT_ACK;
            end else begin
              oe_q      <= ~tx_q[6];
              tx_q      <= {tx_q[6:0], 1'b0};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign wr_en_o   = (state_q == S_WDAT) && byte_done && !start_i && !stop_i;
  assign wr_addr_o = ptr_q;
  assign wr_data_o = shift_q;
  assign rd_addr_o = ptr_q;
  assign sda_oe_o  = oe_q;

  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> state_q == S_IDLE);  // R9
  AST_START_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == S_ADDR && ptr_q == '0));  // R9
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_IDLE |-> !oe_q);  // R1
  AST_PTR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> (ptr_q == PTR_W'($past(ptr_q) + 1'b1) || &$past(ptr_q)));  // R3

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import clkcfg_pkg::*;
#(
  parameter int unsigned PTR_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               wr_en_i,
  input  logic [PTR_W-1:0]   wr_addr_i,
  input  logic [7:0]         wr_data_i,
  input  logic [PTR_W-1:0]   rd_addr_i,
  output logic [7:0]         rd_data_o,
  output logic [LAST_RW:0][7:0] regs_o
);
  localparam int unsigned IDX_W = $clog2(LAST_RW + 1);

  logic [LAST_RW:0][7:0] rf_q;
  logic [STRAP_W-1:0]    strap_q;
  logic                  strap_vld_q;
  logic [7:0]            rd_base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i <= LAST_RW; i++) rf_q[i] <= reg_default(i);
    end else if (wr_en_i && wr_addr_i <= PTR_W'(LAST_RW)) begin
      rf_q[wr_addr_i[IDX_W-1:0]] <= wr_data_i;
    end
  end

  // straps are sampled once, in the first cycle after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q     <= '0;
      strap_vld_q <= 1'b0;
    end else if (!strap_vld_q) begin
      strap_q     <= strap_i;
      strap_vld_q <= 1'b1;
    end
  end

  always_comb begin
    rd_base = rf_q[rd_addr_i[IDX_W-1:0]];
    if (rd_addr_i <= PTR_W'(LAST_RW))
      rd_data_o = (rd_addr_i == PTR_W'(1)) ? {strap_q, rd_base[2:0]} : rd_base;
    else if (rd_addr_i == PTR_W'(ID0_IDX)) rd_data_o = ID0_VAL;
    else if (rd_addr_i == PTR_W'(ID1_IDX)) rd_data_o = ID1_VAL;
    else rd_data_o = 8'h00;
  end

  assign regs_o = rf_q;

  AST_STRAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_vld_q |=> $stable(strap_q));  // R6
  AST_QUIET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rf_q));  // R2
  AST_RO_DISCARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i > PTR_W'(LAST_RW)) |=> $stable(rf_q));  // R7

endmodule

// File: rtl/clkgen_cfg_i2c.sv
module clkgen_cfg_i2c
  import clkcfg_pkg::*;
#(
  parameter logic [6:0]  SLV_ADDR    = 7'h69,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PTR_W       = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_fs_i,
  output logic [7:0]         freq_sel_o,
  output logic [2:0]         ss_cfg_o,
  output logic [23:0]        clk_en_o,
  output logic [1:0]         cpu_en_o,
  output logic [2:0]         skew_sdram_o,
  output logic [2:0]         skew_3v66_o,
  output logic [39:0]        mn_cfg_o
);
  logic             sda_s, scl_rise, scl_fall, start, stop, wr_en;
  logic [PTR_W-1:0] wr_addr, rd_addr;
  logic [7:0]       wr_data, rd_data;
  logic [LAST_RW:0][7:0] regs;

  i2c_sync_detect #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_cfg_fsm #(.SLV_ADDR(SLV_ADDR), .PTR_W(PTR_W)) i_fsm (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_i(sda_s),
    .start_i(start), .stop_i(stop),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .sda_oe_o
  );

  cfg_regbank #(.PTR_W(PTR_W)) i_regs (
    .clk_i, .rst_ni, .strap_i(strap_fs_i),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .regs_o(regs)
  );

  assign freq_sel_o   = regs[0];
  assign ss_cfg_o     = regs[1][2:0];
  assign clk_en_o     = {regs[4], regs[3], regs[2]};
  assign skew_sdram_o = regs[5][7:5];
  assign skew_3v66_o  = regs[5][4:2];
  assign cpu_en_o     = regs[5][1:0];
  assign mn_cfg_o     = {regs[10], regs[9], regs[8], regs[7], regs[6]};

endmodule

// File: tb/test_clkgen_cfg_i2c.sv
module test_clkgen_cfg_i2c;
  localparam logic [6:0] ADDR  = 7'h69;
  localparam logic [4:0] STRAP = 5'b10110;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [7:0] freq_sel; logic [2:0] ss_cfg; logic [23:0] clk_en;
  logic [1:0] cpu_en; logic [2:0] sk_sd, sk_66; logic [39:0] mn_cfg;
  wire sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0;
  bit model_ok = 1'b0;
  logic [7:0] m [0:10];
  logic [7:0] wq [$];

  always #4 clk = ~clk;

  clkgen_cfg_i2c #(.SLV_ADDR(ADDR)) i_clkgen_cfg_i2c (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .strap_fs_i(STRAP), .freq_sel_o(freq_sel), .ss_cfg_o(ss_cfg), .clk_en_o(clk_en),
    .cpu_en_o(cpu_en), .skew_sdram_o(sk_sd), .skew_3v66_o(sk_66), .mn_cfg_o(mn_cfg));

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(int i);
    if (i == 1) return {STRAP, m[1][2:0]};   // R6
    if (i <= 10) return m[i];
    if (i == 11) return 8'h50;               // R7
    if (i == 12) return 8'h12;
    return 8'h00;                            // R8
  endfunction

  // R5 field mapping, checked every clock while the model is current
  always @(negedge clk) if (rst_n && model_ok)
    check("R5 port fields",
          {freq_sel, ss_cfg, clk_en, cpu_en, sk_sd, sk_66, mn_cfg},
          {m[0], m[1][2:0], m[4], m[3], m[2], m[5][1:0], m[5][7:5], m[5][4:2],
           m[10], m[9], m[8], m[7], m[6]});

  task automatic wq_();  repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq_(); scl = 1'b1; wq_(); sda_m = 1'b0; wq_(); scl = 1'b0; wq_();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq_(); scl = 1'b1; wq_(); sda_m = 1'b1; wq_();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int k = 7; k >= 0; k--) begin
      sda_m = b[k]; wq_(); scl = 1'b1; wq_(); wq_(); scl = 1'b0; wq_();
    end
    sda_m = 1'b1; wq_(); scl = 1'b1; wq_(); ack = ~sda_line; wq_(); scl = 1'b0; wq_();
  endtask

  task automatic rd_byte(input bit nack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int k = 7; k >= 0; k--) begin
      wq_(); scl = 1'b1; wq_(); d[k] = sda_line; wq_(); scl = 1'b0;
    end
    wq_(); sda_m = nack; wq_(); scl = 1'b1; wq_(); wq_(); scl = 1'b0; wq_(); sda_m = 1'b1;
  endtask

  // write transfer: address, two filler bytes, then wq contents from register 0
  task automatic wr_xfer(logic [6:0] a, logic [7:0] cmd, logic [7:0] cnt, bit do_stop);
    logic ack; bit hit = (a == ADDR);
    i2c_start();
    wr_byte({a, 1'b0}, ack); check(hit ? "R1 addr ack" : "R1 addr nack", ack, hit);
    wr_byte(cmd, ack); check("R2 cmd ack", ack, hit);
    wr_byte(cnt, ack); check("R2 cnt ack", ack, hit);
    for (int p = 0; p < wq.size(); p++) begin
      if (hit) model_ok = 1'b0;
      wr_byte(wq[p], ack); check("R3 data ack", ack, hit);
      if (hit && p <= 10) m[p] = wq[p];
      model_ok = 1'b1;
    end
    if (do_stop) i2c_stop();
  endtask

  task automatic rd_xfer(int n, string req);
    logic ack; logic [7:0] d;
    i2c_start();
    wr_byte({ADDR, 1'b1}, ack); check("R1 read addr ack", ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i == n - 1, d);
      check(req, d, exp_rd(i));
    end
    i2c_stop();
  endtask

  initial begin
    for (int i = 0; i <= 10; i++) m[i] = 8'h00;
    m[1] = 8'h01; m[2] = 8'hFF; m[3] = 8'hFF; m[4] = 8'hFF; m[5] = 8'h93;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R4 reset values at the ports
    check("R4 clk_en reset", clk_en, 24'hFFFFFF);
    check("R4 reg5 reset", {sk_sd, sk_66, cpu_en}, 8'h93);
    check("R4 ss reset", ss_cfg, 3'b001);
    check("R4 freq reset", freq_sel, 8'h00);
    model_ok = 1'b1;
    rd_xfer(13, "R4 R6 R7 reset readback");

    // full-map write incl. ID and beyond-map bytes
    wq.delete();
    for (int i = 0; i < 16; i++) wq.push_back(8'(8'h3C + 8'(i) * 8'h1B));
    wr_xfer(ADDR, 8'hA5, 8'h10, 1'b1);
    rd_xfer(15, "R3 R7 R8 readback after full write");

    // wrong address: no ack, nothing changes
    wq.delete();
    for (int i = 0; i < 4; i++) wq.push_back(8'h00);
    wr_xfer(7'h2A, 8'h00, 8'h04, 1'b1);
    rd_xfer(6, "R1 ignored after mismatch");

    // filler contents ignored, short write
    wq.delete(); wq.push_back(8'hC3); wq.push_back(8'hFA); wq.push_back(8'h0F);
    wr_xfer(ADDR, 8'hFF, 8'h00, 1'b1);
    rd_xfer(4, "R2 short write");

    // field mapping
    wq.delete();
    wq.push_back(8'h81); wq.push_back(8'h06); wq.push_back(8'h5A);
    wq.push_back(8'hA5); wq.push_back(8'h3C); wq.push_back(8'b011_010_01);
    wr_xfer(ADDR, 8'h01, 8'h06, 1'b1);
    check("R5 skew_sdram", sk_sd, 3'b011);
    check("R5 skew_3v66", sk_66, 3'b010);
    check("R5 cpu_en", cpu_en, 2'b01);
    check("R5 ss_cfg", ss_cfg, 3'b110);

    // repeated start directly after a data ack restarts at register 0
    wq.delete(); wq.push_back(8'h11); wq.push_back(8'h22);
    wr_xfer(ADDR, 8'h00, 8'h02, 1'b0);
    wq.delete(); wq.push_back(8'h77);
    wr_xfer(ADDR, 8'h00, 8'h01, 1'b1);
    check("R9 restart reg0", freq_sel, 8'h77);
    check("R9 restart reg1 kept", ss_cfg, 3'b010);

    // stop in the middle of an address byte
    i2c_start();
    for (int k = 0; k < 4; k++) begin
      sda_m = k[0]; wq_(); scl = 1'b1; wq_(); wq_(); scl = 1'b0; wq_();
    end
    i2c_stop();
    check("R9 no drive after stop", sda_oe, 1'b0);
    rd_xfer(2, "R9 R8 read after aborted byte");

    // early NACK then a new read starts at register 0
    rd_xfer(1, "R8 early nack");
    rd_xfer(13, "R8 full read from 0");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule